// File: doc/BRIEF.md
# Display Enable Sequencer

This block switches the picture output of a display controller on and off. It does this by issuing a short series of writes to the controller's display control register, which sits at index 0x07. Between some of the writes it waits about two frame times, so that the gate drivers and the source outputs settle before the next stage. The block also keeps a display-invert setting. It folds that setting into the control words. When the display is already showing, a change of the setting takes effect at once.

Software or a higher-level controller sends single-cycle enable and disable requests and drives a level that selects reversed display. A separate power sequencer reports whether the panel supply is up. When an enable is requested while the supply is down, this block raises a power request and waits for the supply to come up. Each register write leaves on a valid/acknowledge port towards a bus framer. A 1 ms strobe times the settling waits. A status flag tells the rest of the chip whether the display is showing.

Top module: `disp_enable_seq`

## Requirements
- R1: After reset, `disp_on`, `wr_valid` and `pwr_req` are all low.
- R2: Every write presents `wr_index` = 0x07. Once `wr_valid` is high it stays high, with `wr_value` unchanged, until a cycle in which `wr_ack` is high.
- R3: If an enable is requested while `pwr_ok` is low, the block raises `pwr_req`. It issues no write until `pwr_ok` is high.
- R4: An enable writes four words in this order: 0x0001, 0x0021|V, 0x0023|V, 0x0033|V. V is 0x0004 when `invert` is 0 and 0x0000 when `invert` is 1.
- R5: Two of the enable writes follow a settling wait: the one after 0x0001 and the one before 0x0033|V. Two of the disable writes also follow a wait: the one after 0x0032|V and the final 0x0000. Each wait lasts `WAIT_TICKS` `ms_tick` pulses, and counting starts after the preceding write is acknowledged.
- R6: `disp_on` rises only after the final enable write (0x0033|V) has been acknowledged.
- R7: A disable lowers `disp_on` before its first write. It then writes 0x0032|V, 0x0022|V and 0x0000, in that order.
- R8: A change of `invert` while the display is on produces exactly one write of 0x0033|V, with V taken from the new setting.
- R9: A change of `invert` while the display is off produces no write. The next enable uses the new setting.
- R10: An enable request while the display is on, or a disable request while it is off, produces no write and no change of `disp_on`.
- R11: A disable request that arrives during an enable sequence waits until the enable completes. It is then carried out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Single-cycle request to turn the display on |
| dis_req | input | 1 | Single-cycle request to turn the display off |
| invert | input | 1 | 1 selects reversed display |
| pwr_ok | input | 1 | Panel supply is up |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| wr_ack | input | 1 | Framer accepts the presented write |
| wr_valid | output | 1 | A register write is presented |
| wr_index | output | IDX_W | Register index of the write (0x07) |
| wr_value | output | 16 | Control word to write |
| pwr_req | output | 1 | Request to the power sequencer to bring the supply up |
| disp_on | output | 1 | Display output is on |

## Verification
The assertions assume that the framer raises `wr_ack` only while `wr_valid` is high, and that `ms_tick` and the request inputs are one-cycle pulses. They also assume that `pwr_ok`, once high, stays high through an enable. The bench's responder follows these rules. It acknowledges a presented write after 0, 1 or 2 cycles. It strobes the tick every third cycle. It lowers the supply only between sequences, and raises it a fixed delay after it sees `pwr_req`. The bench changes `invert` and the request pulses only on falling edges, and it waits for the write port to go quiet before it starts the next stimulus.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWER,
        ST_STEP,
        ST_ACK,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_UP,
        MODE_DOWN,
        MODE_REFRESH
    } seq_mode_e;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_WAIT,
        OP_END
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [15:0] value;
    } seq_op_t;

    localparam int unsigned STEP_W = 3;

    // Normal (non-reversed) display contributes this bit to the staged words
    localparam logic [15:0] INV_NORMAL_BIT = 16'h0004;

    localparam logic [15:0] CV_BLANK    = 16'h0001;
    localparam logic [15:0] CV_GATE     = 16'h0021;
    localparam logic [15:0] CV_GATE_DRV = 16'h0023;
    localparam logic [15:0] CV_FULL     = 16'h0033;
    localparam logic [15:0] CV_SHUT1    = 16'h0032;
    localparam logic [15:0] CV_SHUT2    = 16'h0022;
    localparam logic [15:0] CV_OFF      = 16'h0000;

    function automatic logic [15:0] inv_term(input logic reversed);
        return reversed ? 16'h0000 : INV_NORMAL_BIT;
    endfunction

    function automatic seq_op_t op_wr(input logic [15:0] v);
        seq_op_t o;
        o.kind  = OP_WRITE;
        o.value = v;
        return o;
    endfunction

    function automatic seq_op_t op_kind(input op_kind_e k);
        seq_op_t o;
        o.kind  = k;
        o.value = 16'h0000;
        return o;
    endfunction

    // Staged program: each mode is a short list of writes and waits
    function automatic seq_op_t program_op(input seq_mode_e mode,
                                           input logic [STEP_W-1:0] step,
                                           input logic reversed);
        seq_op_t     o;
        logic [15:0] t;
        t = inv_term(reversed);
        o = op_kind(OP_END);
        case (mode)
            MODE_UP: begin
                case (step)
                    3'd0:    o = op_wr(CV_BLANK);
                    3'd1:    o = op_kind(OP_WAIT);
                    3'd2:    o = op_wr(CV_GATE | t);
                    3'd3:    o = op_wr(CV_GATE_DRV | t);
                    3'd4:    o = op_kind(OP_WAIT);
                    3'd5:    o = op_wr(CV_FULL | t);
                    default: o = op_kind(OP_END);
                endcase
            end
            MODE_DOWN: begin
                case (step)
                    3'd0:    o = op_wr(CV_SHUT1 | t);
                    3'd1:    o = op_kind(OP_WAIT);
                    3'd2:    o = op_wr(CV_SHUT2 | t);
                    3'd3:    o = op_kind(OP_WAIT);
                    3'd4:    o = op_wr(CV_OFF);
                    default: o = op_kind(OP_END);
                endcase
            end
            MODE_REFRESH: begin
                if (step == 3'd0) o = op_wr(CV_FULL | t);
                else              o = op_kind(OP_END);
            end
            default: o = op_kind(OP_END);
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dseq_tick_timer.sv
module dseq_tick_timer #(
    parameter int unsigned WAIT_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(WAIT_TICKS + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = LOAD_VAL;
        end else if (tick && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    assign done = !start && tick && (tmr_q.cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LOAD_VAL); // R5
    AST_TIMER_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

endmodule

// File: rtl/dseq_wr_port.sv
module dseq_wr_port #(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned REG_INDEX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      load_value,
    input  logic             wr_ack,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_index,
    output logic [15:0]      wr_value,
    output logic             accepted
);
    typedef struct packed {
        logic        valid;
        logic [15:0] value;
    } port_t;

    port_t port_d, port_q;

    assign accepted = port_q.valid && wr_ack;

    always_comb begin
        port_d = port_q;
        if (accepted) port_d.valid = 1'b0;
        if (load) begin
            port_d.valid = 1'b1;
            port_d.value = load_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign wr_valid = port_q.valid;
    assign wr_value = port_q.value;
    assign wr_index = IDX_W'(REG_INDEX);

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_value))); // R2
    AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !wr_valid); // R2

endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
    import dseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_req,
    input  logic        dis_req,
    input  logic        reversed,
    input  logic        pwr_ok,
    input  logic        wr_accepted,
    input  logic        wait_done,
    output logic        load,
    output logic [15:0] load_value,
    output logic        wait_start,
    output logic        pwr_req,
    output logic        disp_on
);
    typedef struct packed {
        seq_state_e        state;
        seq_mode_e         mode;
        logic [STEP_W-1:0] step;
        logic              en_pend;
        logic              dis_pend;
        logic              shown_rev;
        logic              on;
    } ctrl_t;

    ctrl_t   ctl_d, ctl_q;
    seq_op_t cur_op;

    assign cur_op = program_op(ctl_q.mode, ctl_q.step, reversed);

    always_comb begin
        ctl_d      = ctl_q;
        load       = 1'b0;
        load_value = 16'h0000;
        wait_start = 1'b0;

        if (en_req)  ctl_d.en_pend  = 1'b1;
        if (dis_req) ctl_d.dis_pend = 1'b1;

        case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.on) begin
                    // Enable while on is redundant
                    ctl_d.en_pend = 1'b0;
                    if (ctl_q.dis_pend) begin
                        ctl_d.dis_pend = 1'b0;
                        ctl_d.on       = 1'b0;
                        ctl_d.mode     = MODE_DOWN;
                        ctl_d.step     = '0;
                        ctl_d.state    = ST_STEP;
                    end else if (reversed != ctl_q.shown_rev) begin
                        ctl_d.mode  = MODE_REFRESH;
                        ctl_d.step  = '0;
                        ctl_d.state = ST_STEP;
                    end
                end else begin
                    // Disable while off is redundant
                    ctl_d.dis_pend = 1'b0;
                    if (ctl_q.en_pend) begin
                        ctl_d.en_pend = 1'b0;
                        ctl_d.mode    = MODE_UP;
                        ctl_d.step    = '0;
                        ctl_d.state   = pwr_ok ? ST_STEP : ST_POWER;
                    end
                end
            end
            ST_POWER: begin
                if (pwr_ok) ctl_d.state = ST_STEP;
            end
            ST_STEP: begin
                case (cur_op.kind)
                    OP_WRITE: begin
                        load            = 1'b1;
                        load_value      = cur_op.value;
                        ctl_d.shown_rev = reversed;
                        ctl_d.state     = ST_ACK;
                    end
                    OP_WAIT: begin
                        wait_start  = 1'b1;
                        ctl_d.state = ST_HOLD;
                    end
                    default: begin
                        if (ctl_q.mode == MODE_UP) ctl_d.on = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end
                endcase
            end
            ST_ACK: begin
                if (wr_accepted) begin
                    ctl_d.step  = ctl_q.step + 1'b1;
                    ctl_d.state = ST_STEP;
                end
            end
            ST_HOLD: begin
                if (wait_done) begin
                    ctl_d.step  = ctl_q.step + 1'b1;
                    ctl_d.state = ST_STEP;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pwr_req = (ctl_q.state == ST_POWER);
    assign disp_on = ctl_q.on;

    AST_PWR_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |-> !disp_on); // R3
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.step <= 3'd6); // R4
    AST_ACK_WAITS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_ACK && !wr_accepted) |=> ctl_q.state == ST_ACK); // R2

endmodule

// File: rtl/disp_enable_seq.sv
module disp_enable_seq
    import dseq_pkg::*;
#(
    parameter int unsigned WAIT_TICKS = 40,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned REG_INDEX  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic             invert,
    input  logic             pwr_ok,
    input  logic             ms_tick,
    input  logic             wr_ack,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_index,
    output logic [15:0]      wr_value,
    output logic             pwr_req,
    output logic             disp_on
);
    logic        load;
    logic [15:0] load_value;
    logic        accepted;
    logic        wait_start;
    logic        wait_done;

    dseq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .reversed    (invert),
        .pwr_ok      (pwr_ok),
        .wr_accepted (accepted),
        .wait_done   (wait_done),
        .load        (load),
        .load_value  (load_value),
        .wait_start  (wait_start),
        .pwr_req     (pwr_req),
        .disp_on     (disp_on)
    );

    dseq_tick_timer #(
        .WAIT_TICKS (WAIT_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wait_start),
        .tick  (ms_tick),
        .done  (wait_done)
    );

    dseq_wr_port #(
        .IDX_W     (IDX_W),
        .REG_INDEX (REG_INDEX)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_value (load_value),
        .wr_ack     (wr_ack),
        .wr_valid   (wr_valid),
        .wr_index   (wr_index),
        .wr_value   (wr_value),
        .accepted   (accepted)
    );

    AST_ON_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_on) |-> (!wr_valid && ((wr_value & ~INV_NORMAL_BIT) == CV_FULL))); // R6
    AST_OFF_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_on) |-> !wr_valid); // R7
    AST_NO_WRITE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req |-> !wr_valid); // R3

endmodule

// File: tb/disp_enable_seq_bench.sv
`timescale 1ns/1ps
module disp_enable_seq_bench;
    localparam int WAIT = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_req, dis_req, invert, pwr_ok, ms_tick, wr_ack;
    logic        wr_valid, pwr_req, disp_on;
    logic [7:0]  wr_index;
    logic [15:0] wr_value;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [15:0] logv [0:63];
    logic [7:0]  logi [0:63];
    int          loggap [0:63];
    int nlog = 0;
    int ticks_since = 0;
    int on_rise_n = -1;
    int on_fall_n = -1;
    int pwr_rise_n = -1;
    int ack_lat = 0;
    int pwr_epoch = 0;

    always #4 clk = ~clk;

    disp_enable_seq #(.WAIT_TICKS(WAIT)) u_disp_enable_seq (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .invert(invert), .pwr_ok(pwr_ok), .ms_tick(ms_tick), .wr_ack(wr_ack),
        .wr_valid(wr_valid), .wr_index(wr_index), .wr_value(wr_value),
        .pwr_req(pwr_req), .disp_on(disp_on)
    );

    // Framer, tick source and power sequencer model
    initial begin : responder
        int acnt = 0;
        int tcnt = 0;
        int pcnt = 0;
        int seen_epoch = 0;
        logic prev_valid = 1'b0;
        logic prev_on = 1'b0;
        wr_ack = 1'b0;
        ms_tick = 1'b0;
        pwr_ok = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1) begin
                wr_ack = 1'b0;
                ms_tick = 1'b0;
                acnt = 0;
                continue;
            end
            tcnt++;
            ms_tick = (tcnt % 3 == 0);
            if (ms_tick) ticks_since++;
            if (pwr_epoch != seen_epoch) begin
                seen_epoch = pwr_epoch;
                pwr_ok = 1'b0;
                pcnt = 0;
            end else if (!pwr_ok && pwr_req) begin
                pcnt++;
                if (pcnt >= 20) begin
                    pwr_ok = 1'b1;
                    pwr_rise_n = nlog;
                end
            end
            if (disp_on && !prev_on) on_rise_n = nlog;
            if (!disp_on && prev_on) on_fall_n = nlog;
            prev_on = disp_on;
            if (wr_valid && !prev_valid && nlog < 64) loggap[nlog] = ticks_since;
            prev_valid = wr_valid;
            if (wr_valid) begin
                if (acnt >= ack_lat) begin
                    wr_ack = 1'b1;
                    acnt = 0;
                end else begin
                    wr_ack = 1'b0;
                    acnt++;
                end
            end else begin
                wr_ack = 1'b0;
                acnt = 0;
            end
            if (wr_valid && wr_ack) begin
                if (nlog < 64) begin
                    logv[nlog] = wr_value;
                    logi[nlog] = wr_index;
                end
                nlog++;
                ticks_since = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_gap(input string tag, input int g);
        tests++;
        if (g < WAIT || g > WAIT + 1) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, g, WAIT, WAIT + 1);
        end
    endtask

    task automatic pulse_en();
        @(negedge clk); en_req = 1'b1;
        @(negedge clk); en_req = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); dis_req = 1'b1;
        @(negedge clk); dis_req = 1'b0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 400) begin
            @(negedge clk);
            if (!wr_valid && !pwr_req) q++;
            else q = 0;
        end
    endtask

    function automatic int vterm(input logic inv);
        return inv ? 0 : 4;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int base;
        int v;
        logic cur;
        rst_n = 1'b0;
        en_req = 1'b0;
        dis_req = 1'b0;
        invert = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 disp_on", disp_on, 0);
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 pwr_req", pwr_req, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int inv = 0; inv < 2; inv++) begin
            for (int lat = 0; lat < 3; lat++) begin
                ack_lat = lat;
                cur = inv[0];
                invert = cur;
                if (lat == 0) pwr_epoch++;
                repeat (3) @(negedge clk);
                base = nlog;
                v = vterm(cur);
                pulse_en();
                quiet();
                chk("R4 enable write count", nlog - base, 4);
                chk("R4 enable word 0", logv[base], 16'h0001);
                chk("R4 enable word 1", logv[base + 1], 16'h0021 | v);
                chk("R4 enable word 2", logv[base + 2], 16'h0023 | v);
                chk("R4 enable word 3", logv[base + 3], 16'h0033 | v);
                for (int k = 0; k < 4; k++) chk("R2 write index", logi[base + k], 8'h07);
                chk_gap("R5 enable wait 1", loggap[base + 1]);
                chk_gap("R5 enable wait 2", loggap[base + 3]);
                if (lat == 0) chk("R3 no write before power", pwr_rise_n, base);
                chk("R6 disp_on after enable", disp_on, 1);
                chk("R6 rise after final write", on_rise_n, base + 4);

                base = nlog;
                pulse_en();
                quiet();
                chk("R10 redundant enable writes", nlog - base, 0);
                chk("R10 redundant enable disp_on", disp_on, 1);

                cur = ~cur;
                invert = cur;
                v = vterm(cur);
                quiet();
                chk("R8 invert refresh count", nlog - base, 1);
                chk("R8 invert refresh word", logv[base], 16'h0033 | v);

                base = nlog;
                pulse_dis();
                quiet();
                chk("R7 off before first write", on_fall_n, base);
                chk("R7 disable write count", nlog - base, 3);
                chk("R7 disable word 0", logv[base], 16'h0032 | v);
                chk("R7 disable word 1", logv[base + 1], 16'h0022 | v);
                chk("R7 disable word 2", logv[base + 2], 16'h0000);
                chk_gap("R5 disable wait 1", loggap[base + 1]);
                chk_gap("R5 disable wait 2", loggap[base + 2]);
                chk("R7 disp_on after disable", disp_on, 0);

                base = nlog;
                pulse_dis();
                quiet();
                chk("R10 redundant disable writes", nlog - base, 0);
                chk("R10 redundant disable disp_on", disp_on, 0);

                invert = ~invert;
                quiet();
                chk("R9 invert while off writes", nlog - base, 0);
            end
        end

        // R9: stored setting used by the next enable
        ack_lat = 1;
        invert = 1'b1;
        base = nlog;
        quiet();
        chk("R9 stored invert no write", nlog - base, 0);
        pulse_en();
        quiet();
        chk("R9 enable uses stored invert", logv[base + 1], 16'h0021);
        chk("R9 final word uses stored invert", logv[base + 3], 16'h0033);
        pulse_dis();
        quiet();

        // R11: disable during enable is deferred
        base = nlog;
        pulse_en();
        repeat (30) @(negedge clk);
        pulse_dis();
        quiet();
        chk("R11 total writes", nlog - base, 7);
        chk("R11 enable finished first", logv[base + 3], 16'h0033);
        chk("R11 disable follows", logv[base + 4], 16'h0032);
        chk("R11 last word", logv[base + 6], 16'h0000);
        chk("R11 rise point", on_rise_n, base + 4);
        chk("R11 fall point", on_fall_n, base + 4);
        chk("R11 final disp_on", disp_on, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule